// File: doc/BRIEF.md
# Serial-to-Nibble Deserializer with Bit Slip

This block turns a one-bit serial stream into 4-bit parallel words. Everything runs on the serial clock. A divide-by-four phase counter produces a registered parallel clock. On the rising edge of that parallel clock, a capture register takes the last four serial bits as one word.

A receiver realigns word boundaries with the sync input. Sync must be sampled high on two consecutive serial edges to count. Each such pulse holds the phase counter for exactly one serial cycle. The word in progress then spans five serial bits, and its oldest bit is discarded. All later words start one bit later in the stream.

A small state machine qualifies the sync input. It has three states:
- Q_IDLE waits for sync. A high sample moves it to Q_COUNT.
- Q_COUNT counts consecutive high samples. A low sample returns it to Q_IDLE. The second high sample issues the slip and moves it to Q_HELD.
- Q_HELD waits until sync goes low, then returns to Q_IDLE.

A synchronous reset forces Q_IDLE from any state.

Top module: `serial_quad_deser`

## Requirements
- R1: On every rising serial clock edge, one bit is taken from ser_in. In each output word, the earliest received bit is par_word[3] and the most recent bit is par_word[0].
- R2: With no slip, par_clk is high for two serial cycles and low for two, so it runs at one quarter of the serial clock rate.
- R3: par_word changes only on a serial edge where par_clk goes from low to high. At every other edge it holds its value.
- R4: The word captured at a par_clk rising edge holds the four bits sampled at that edge and the three edges before it. A new word is captured every four serial bits.
- R5: A sync pulse sampled high on only one serial edge has no effect on par_clk timing or on the words.
- R6: A sync pulse sampled high on two or more consecutive edges causes exactly one slip, however long it lasts. A further slip requires at least one low sample of sync first.
- R7: A slip extends the current par_clk phase by one serial cycle. The word that spans the slip is built from five received bits, and its oldest bit is dropped. Every later word boundary moves one bit later.
- R8: The slip is applied on the edge that samples sync high for the second time. This is well within two parallel clock periods of the rising edge of sync.
- R9: A synchronous reset clears the shift register and par_word to 0 and drives par_clk low. After reset is released, the first word is captured on the second serial edge. Bit positions received before reset read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial bit clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| sync_in | input | 1 | Realignment request, active high |
| par_word | output | 4 | Parallel word, earliest bit in bit 3 |
| par_clk | output | 1 | Parallel clock at a quarter of the serial rate |

## Verification
Some rules are checked by the assertions on every cycle:
- par_word never changes except at a par_clk rise.
- Each par_clk phase lasts two or three serial cycles, never more or fewer.
- A slip request only follows two high sync samples, appears on exactly the second one, and is never issued twice in a row.

Other behaviour needs the bench scenarios. These cover bit order and word content, the drop of exactly one bit, and single-cycle pulses leaving the framing alone. They also cover back-to-back pulses giving one slip each, and the framing restart after a mid-stream reset. The bench shows these by predicting every capture edge and word from its own bit history, with slips placed at every phase offset.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;
    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_COUNT = 2'd1,
        Q_HELD  = 2'd2
    } qual_state_t;
endpackage

// File: rtl/slip_qualifier.sv
`timescale 1ns/1ps
module slip_qualifier #(
    parameter int SYNC_MIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic slip_req
);
    import deser_pkg::*;

    localparam int HC_W = $clog2(SYNC_MIN + 1);

    qual_state_t      st, st_nx;
    logic [HC_W-1:0]  hc, hc_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= Q_IDLE;
            hc <= '0;
        end else begin
            st <= st_nx;
            hc <= hc_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        hc_nx = hc;
        unique case (st)
            Q_IDLE: begin
                if (sync_in) begin
                    st_nx = Q_COUNT;
                    hc_nx = HC_W'(1);
                end
            end
            Q_COUNT: begin
                if (!sync_in) begin
                    st_nx = Q_IDLE;
                    hc_nx = '0;
                end else if (hc == HC_W'(SYNC_MIN - 1)) begin
                    st_nx = Q_HELD;
                    hc_nx = '0;
                end else begin
                    hc_nx = hc + 1'b1;
                end
            end
            Q_HELD: begin
                if (!sync_in) st_nx = Q_IDLE;
            end
            default: begin
                st_nx = Q_IDLE;
                hc_nx = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        slip_req = (st == Q_COUNT) && sync_in && (hc == HC_W'(SYNC_MIN - 1));
    end
endmodule

// File: rtl/phase_divider.sv
`timescale 1ns/1ps
module phase_divider #(
    parameter int WORD_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic stall,
    output logic par_clk,
    output logic cap_en
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int HALF  = WORD_W / 2;

    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             pclk_q;

    always_comb begin
        if (stall)
            cnt_nx = cnt;
        else if (cnt == CNT_W'(WORD_W - 1))
            cnt_nx = '0;
        else
            cnt_nx = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            pclk_q <= 1'b0;
        end else begin
            cnt    <= cnt_nx;
            pclk_q <= (cnt_nx >= CNT_W'(HALF));
        end
    end

    always_comb begin
        cap_en  = !stall && (cnt == CNT_W'(HALF - 1));
        par_clk = pclk_q;
    end
endmodule

// File: rtl/sipo_capture.sv
`timescale 1ns/1ps
module sipo_capture #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              cap_en,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sh_q, word_q, shifted;

    always_comb begin
        shifted = {sh_q[WORD_W-2:0], ser_in};
        word    = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            word_q <= '0;
        end else begin
            sh_q <= shifted;
            if (cap_en) word_q <= shifted;
        end
    end
endmodule

// File: rtl/serial_quad_deser.sv
`timescale 1ns/1ps
module serial_quad_deser #(
    parameter int WORD_W   = 4,
    parameter int SYNC_MIN = 2
) (
    input  logic              clk_ser,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              sync_in,
    output logic [WORD_W-1:0] par_word,
    output logic              par_clk
);
    logic slip_req;
    logic cap_en;

    slip_qualifier #(.SYNC_MIN(SYNC_MIN)) u_qual (
        .clk      (clk_ser),
        .rst      (rst),
        .sync_in  (sync_in),
        .slip_req (slip_req)
    );

    phase_divider #(.WORD_W(WORD_W)) u_phase (
        .clk     (clk_ser),
        .rst     (rst),
        .stall   (slip_req),
        .par_clk (par_clk),
        .cap_en  (cap_en)
    );

    sipo_capture #(.WORD_W(WORD_W)) u_sipo (
        .clk    (clk_ser),
        .rst    (rst),
        .ser_in (ser_in),
        .cap_en (cap_en),
        .word   (par_word)
    );
endmodule

// File: rtl/deser_chk.sv
`timescale 1ns/1ps
module deser_chk #(
    parameter int WORD_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic              par_clk,
    input logic [WORD_W-1:0] par_word,
    input logic              slip_req
);
    logic [2:0] since_rst;
    logic       settled;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end
    assign settled = (since_rst >= 3'd3);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(par_clk) |-> $stable(par_word));

    // R2
    pclk_low_min_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && $rose(par_clk)) |-> !$past(par_clk, 2));

    // R2
    pclk_high_min_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && $fell(par_clk)) |-> $past(par_clk, 2));

    // R7
    pclk_low_max_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && !par_clk && !$past(par_clk) && !$past(par_clk, 2)) |=> par_clk);

    // R7
    pclk_high_max_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && par_clk && $past(par_clk) && $past(par_clk, 2)) |=> !par_clk);

    // R5
    slip_qual_chk: assert property (@(posedge clk) disable iff (rst)
        slip_req |-> (sync_in && $past(sync_in)));

    // R6
    slip_once_chk: assert property (@(posedge clk) disable iff (rst)
        slip_req |=> !slip_req);

    // R8
    slip_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && sync_in && $past(sync_in) && !$past(sync_in, 2)) |-> slip_req);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (par_word == '0 && !par_clk));
endmodule

bind serial_quad_deser deser_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk_ser),
    .rst      (rst),
    .sync_in  (sync_in),
    .par_clk  (par_clk),
    .par_word (par_word),
    .slip_req (slip_req)
);

// File: tb/tb_serial_quad_deser.sv
`timescale 1ns/1ps
module tb_serial_quad_deser;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       sync_in = 1'b0;
    logic [3:0] par_word;
    logic       par_clk;

    always #2.5 clk = ~clk;

    serial_quad_deser dut (
        .clk_ser  (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .sync_in  (sync_in),
        .par_word (par_word),
        .par_clk  (par_clk)
    );

    int         checks = 0;
    int         fails  = 0;
    int         k = 0;
    int         rbase = 0;
    int         next_cap = 1;
    int         run = 0;
    int         since = 99;
    bit         hist [0:8191];
    logic [3:0] prev_word = 4'h0;
    logic       prev_pclk = 1'b0;
    logic [15:0] lf = 16'hACE1;
    string      tag = "";

    function automatic bit h(int i);
        return (i < rbase) ? 1'b0 : hist[i];
    endfunction

    function automatic bit rnd();
        logic fb;
        fb = lf[0] ^ lf[2] ^ lf[3] ^ lf[5];
        lf = {fb, lf[15:1]};
        return lf[0];
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] edge=%0d act=%0h exp=%0h", what, tag, k, act, exp);
        end
    endtask

    task automatic tick(bit d, bit s);
        bit         cap;
        logic [3:0] expw;
        ser_in  = d;
        sync_in = s;
        hist[k] = d;
        @(posedge clk);
        if (s) run++; else run = 0;
        if (run == 2) next_cap++;
        cap  = (k == next_cap);
        expw = 4'h0;
        if (cap) begin
            expw = {h(k-3), h(k-2), h(k-1), h(k)};
            next_cap += 4;
        end
        @(negedge clk);
        if (cap) begin
            check(par_word == expw, "R1 R4 word content", par_word, expw);
            check(par_clk && !prev_pclk, "R2 R3 rise at capture", {prev_pclk, par_clk}, 2'b01);
            since = 0;
        end else begin
            since++;
            check(par_word == prev_word, "R3 word hold", par_word, prev_word);
            check(!(par_clk && !prev_pclk), "R5 R7 R8 no rise off capture", {prev_pclk, par_clk}, 2'b00);
            if (since == 1)
                check(par_clk == 1'b1, "R2 high phase", par_clk, 1);
        end
        prev_word = par_word;
        prev_pclk = par_clk;
        k++;
    endtask

    task automatic do_reset();
        rst     = 1'b1;
        sync_in = 1'b0;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            check(par_word == 4'h0 && par_clk == 1'b0, "R9 reset state", {par_clk, par_word}, 0);
        end
        rst       = 1'b0;
        rbase     = k;
        next_cap  = k + 1;
        run       = 0;
        since     = 99;
        prev_word = 4'h0;
        prev_pclk = 1'b0;
    endtask

    initial begin
        tag = "R9 start";
        do_reset();

        tag = "R1 nibble sweep";
        for (int v = 0; v < 16; v++)
            for (int b = 3; b >= 0; b--)
                tick(v[b], 1'b0);

        tag = "R4 pseudo-random";
        repeat (200) tick(rnd(), 1'b0);

        tag = "R5 single-cycle sync";
        for (int off = 0; off < 8; off++) begin
            repeat (off) tick(rnd(), 1'b0);
            tick(rnd(), 1'b1);
            repeat (10) tick(rnd(), 1'b0);
        end

        tag = "R8 two-cycle sync at each offset";
        for (int off = 0; off < 8; off++) begin
            repeat (off) tick(rnd(), 1'b0);
            tick(rnd(), 1'b1);
            tick(rnd(), 1'b1);
            repeat (12) tick(rnd(), 1'b0);
        end

        tag = "R6 long sync";
        repeat (9) tick(rnd(), 1'b1);
        repeat (12) tick(rnd(), 1'b0);
        repeat (30) tick(rnd(), 1'b1);
        repeat (12) tick(rnd(), 1'b0);

        tag = "R7 back-to-back pulses";
        for (int p = 0; p < 3; p++) begin
            tick(rnd(), 1'b1);
            tick(rnd(), 1'b1);
            tick(rnd(), 1'b0);
        end
        repeat (12) tick(rnd(), 1'b0);

        tag = "R9 mid-stream reset";
        tick(rnd(), 1'b1);
        do_reset();
        repeat (40) tick(rnd(), 1'b0);
        tick(rnd(), 1'b1);
        tick(rnd(), 1'b1);
        repeat (20) tick(rnd(), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule